// File: doc/BRIEF.md
# ALU Status Flag Unit

This block sits beside an integer ALU and holds the processor status word. Each cycle it receives two operands, an operation code, a width select (8-bit or 16-bit) and an update strobe. It produces the ALU result combinationally. On a clock edge with the strobe high, it loads the flags that the operation defines. Arithmetic operations (add, subtract) set carry/borrow, half-carry, parity, zero, sign and signed overflow. Logic operations (AND, OR, XOR) set parity, zero and sign, and clear the others. Data moves and control-flow operations leave the whole word untouched.

Three control flags, trap, interrupt enable and direction, change only through dedicated set and clear commands. The interrupt-enable flag gates an external interrupt request. The trap flag raises a debug trap output whenever an operation is issued.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 1 (add) returns (A+B) mod 2^N, where N is 8 when `wide_i`=0 and 16 when `wide_i`=1. In 8-bit mode only the low operand bytes are used and result bits 15:8 are 0. Carry (flag bit 0) is the carry out of bit N-1.
- R2: Opcode 2 (subtract) returns (A-B) mod 2^N. Carry is 1 when A < B unsigned (borrow).
- R3: Overflow (flag bit 5) is set on add when both operands have the same sign and the result sign differs. It is set on subtract when the operand signs differ and the result sign differs from A.
- R4: Auxiliary carry (flag bit 2) is the carry out of bit 3 on add, and is 1 on subtract when A[3:0] < B[3:0].
- R5: Parity (flag bit 1) is 1 when result bits 7:0 hold an even number of ones, in both widths.
- R6: Zero (flag bit 3) is 1 exactly when the N-bit result is 0. Sign (flag bit 4) is result bit N-1.
- R7: Opcodes 3, 4 and 5 (AND, OR, XOR) return the bitwise result. They clear carry, auxiliary carry and overflow, and set parity, zero and sign from the result.
- R8: Opcode 6 (move) returns B masked to N bits. Opcodes 0 (no-op) and 7 (jump) return 0. None of the three changes any flag.
- R9: Reset clears all nine flag bits. Flags change only on a rising clock edge with `upd_i`=1.
- R10: Opcodes 8/9 set/clear trap (bit 6), 10/11 set/clear interrupt enable (bit 7), and 12/13 set/clear direction (bit 8). No other opcode changes bits 8:6, and these commands change no other bit.
- R11: `irq_o` equals `irq_i` AND interrupt enable. `trap_o` equals trap AND `upd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| upd_i | input | 1 | Load flags at this edge |
| irq_i | input | 1 | External interrupt request |
| result_o | output | 16 | ALU result, combinational |
| flags_o | output | 9 | Flags {dir, ien, trap, ovf, sign, zero, aux, par, carry} |
| irq_o | output | 1 | Gated interrupt request |
| trap_o | output | 1 | Debug trap request |

## Verification
The hardest cases to reach are the flag corners that depend on exact operand pairs. Signed overflow at the 0x7F/0x80 and 0x7FFF/0x8000 boundaries, and the half-carry crossing bit 3 against the full carry crossing bit N-1, need particular pairs to fire. The bench therefore crosses every 8-bit first operand with a dense stride of second operands for both add and subtract. It adds explicit 16-bit boundary pairs to a pseudo-random 16-bit sweep. Control flags are set before the sweeps start, so every arithmetic update also shows that they are held.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_W = 9;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_AND = 4'd3,
    OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_MOV = 4'd6,  OP_JMP = 4'd7,
    OP_STF = 4'd8,  OP_CTF = 4'd9,  OP_SIF = 4'd10, OP_CIF = 4'd11,
    OP_SDF = 4'd12, OP_CDF = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trap;
    logic ovf;
    logic sgn;
    logic zero;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  function automatic logic is_logic(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_passive(alu_op_e op);
    return (op == OP_NOP) || (op == OP_MOV) || (op == OP_JMP);
  endfunction
endpackage

// File: rtl/alu_lane.sv
module alu_lane
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         cry_o,
  output logic         aux_o,
  output logic         ovf_o
);
  logic [W:0] ext;
  logic [4:0] nib_sum;

  always_comb begin
    unique case (op_i)
      OP_ADD:  ext = {1'b0, a_i} + {1'b0, b_i};
      OP_SUB:  ext = {1'b0, a_i} - {1'b0, b_i};
      OP_AND:  ext = {1'b0, a_i & b_i};
      OP_OR:   ext = {1'b0, a_i | b_i};
      OP_XOR:  ext = {1'b0, a_i ^ b_i};
      OP_MOV:  ext = {1'b0, b_i};
      default: ext = '0;
    endcase
  end

  assign res_o   = ext[W-1:0];
  assign nib_sum = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]};

  always_comb begin
    cry_o = 1'b0;
    aux_o = 1'b0;
    ovf_o = 1'b0;
    if (op_i == OP_ADD) begin
      cry_o = ext[W];
      aux_o = nib_sum[4];
      ovf_o = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
    end else if (op_i == OP_SUB) begin
      cry_o = ext[W];
      aux_o = a_i[3:0] < b_i[3:0];
      ovf_o = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
    end
  end
endmodule

// File: rtl/alu_flag_next.sv
module alu_flag_next
  import alu_flag_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PAR_W    = 8
) (
  input  alu_op_e           op_i,
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] res_i,
  input  logic              cry_i,
  input  logic              aux_i,
  input  logic              ovf_i,
  input  flags_t            cur_i,
  output flags_t            nxt_o
);
  logic sgn, zero, par;

  assign sgn  = wide_i ? res_i[WIDE_W-1] : res_i[NARROW_W-1];
  assign zero = (res_i == '0);
  assign par  = ~^res_i[PAR_W-1:0];

  always_comb begin
    nxt_o = cur_i;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        nxt_o.cry  = cry_i;
        nxt_o.aux  = aux_i;
        nxt_o.ovf  = ovf_i;
        nxt_o.sgn  = sgn;
        nxt_o.zero = zero;
        nxt_o.par  = par;
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt_o.cry  = 1'b0;
        nxt_o.aux  = 1'b0;
        nxt_o.ovf  = 1'b0;
        nxt_o.sgn  = sgn;
        nxt_o.zero = zero;
        nxt_o.par  = par;
      end
      OP_STF: nxt_o.trap = 1'b1;
      OP_CTF: nxt_o.trap = 1'b0;
      OP_SIF: nxt_o.ien  = 1'b1;
      OP_CIF: nxt_o.ien  = 1'b0;
      OP_SDF: nxt_o.dir  = 1'b1;
      OP_CDF: nxt_o.dir  = 1'b0;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
  import alu_flag_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    upd_i,
  input  alu_op_e op_i,
  input  flags_t  nxt_i,
  output flags_t  flags_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q <= nxt_i;
  end

  assign flags_o = flags_q;

  a_r9_hold_without_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_q));

  a_r8_passive_op_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && is_passive(op_i)) |=> $stable(flags_q));

  a_r7_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && is_logic(op_i)) |=> (!flags_q.cry && !flags_q.ovf && !flags_q.aux));

  a_r10_trap_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OP_STF) |=> flags_q.trap);

  a_r10_arith_keeps_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (op_i == OP_ADD || op_i == OP_SUB))
      |=> $stable({flags_q.dir, flags_q.ien, flags_q.trap}));

  a_r6_zero_not_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.zero |-> !flags_q.sgn);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PAR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDE_W-1:0] op_a_i,
  input  logic [WIDE_W-1:0] op_b_i,
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic              upd_i,
  input  logic              irq_i,
  output logic [WIDE_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o,
  output logic              trap_o
);
  localparam int LANE_N = 2;

  alu_op_e           op;
  logic [WIDE_W-1:0] lane_res [LANE_N];
  logic [LANE_N-1:0] lane_cry, lane_aux, lane_ovf;
  logic              sel;
  flags_t            cur_flags, nxt_flags;

  assign op  = alu_op_e'(op_i);
  assign sel = wide_i;

  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] res;
    alu_lane #(.W(LW)) u_lane (
      .a_i  (op_a_i[LW-1:0]),
      .b_i  (op_b_i[LW-1:0]),
      .op_i (op),
      .res_o(res),
      .cry_o(lane_cry[g]),
      .aux_o(lane_aux[g]),
      .ovf_o(lane_ovf[g])
    );
    if (LW < WIDE_W) begin : g_pad
      assign lane_res[g] = {{(WIDE_W-LW){1'b0}}, res};
    end else begin : g_full
      assign lane_res[g] = res;
    end
  end

  assign result_o = lane_res[sel];

  alu_flag_next #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .PAR_W(PAR_W)) u_next (
    .op_i  (op),
    .wide_i(wide_i),
    .res_i (result_o),
    .cry_i (lane_cry[sel]),
    .aux_i (lane_aux[sel]),
    .ovf_i (lane_ovf[sel]),
    .cur_i (cur_flags),
    .nxt_o (nxt_flags)
  );

  alu_flag_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd_i),
    .op_i   (op),
    .nxt_i  (nxt_flags),
    .flags_o(cur_flags)
  );

  assign flags_o = cur_flags;
  assign irq_o   = irq_i && cur_flags.ien;
  assign trap_o  = cur_flags.trap && upd_i;

  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flags_o[7]);

  a_r1_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> (result_o[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/alu_flag_unit_tb_top.sv
module alu_flag_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] op_a_i = '0, op_b_i = '0;
  logic [3:0]  op_i = '0;
  logic        wide_i = 1'b0, upd_i = 1'b0, irq_i = 1'b0;
  logic [15:0] result_o;
  logic [8:0]  flags_o;
  logic        irq_o, trap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [8:0] model = '0;

  always #4 clk_i = ~clk_i;

  alu_flag_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .op_i(op_i), .wide_i(wide_i), .upd_i(upd_i), .irq_i(irq_i),
    .result_o(result_o), .flags_o(flags_o), .irq_o(irq_o), .trap_o(trap_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned exp_result(int op, int unsigned a, int unsigned b, bit w);
    int unsigned m = w ? 32'hFFFF : 32'hFF;
    a &= m; b &= m;
    case (op)
      1: return (a + b) & m;
      2: return (a - b) & m;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return b;
      default: return 0;
    endcase
  endfunction

  function automatic logic [8:0] exp_flags(int op, int unsigned a, int unsigned b, bit w,
                                           logic [8:0] prev);
    int unsigned m = w ? 32'hFFFF : 32'hFF;
    int unsigned h = w ? 32'h8000 : 32'h80;
    int unsigned r;
    int sa, sb, sr;
    logic [8:0] f = prev;
    a &= m; b &= m;
    r  = exp_result(op, a, b, w);
    sa = (a >= h) ? int'(a) - int'(m + 1) : int'(a);
    sb = (b >= h) ? int'(b) - int'(m + 1) : int'(b);
    if (op >= 1 && op <= 5) begin
      f[1] = ($countones(r & 32'hFF) % 2) == 0;
      f[3] = (r == 0);
      f[4] = (r >= h);
      f[0] = 1'b0; f[2] = 1'b0; f[5] = 1'b0;
      if (op == 1) begin
        f[0] = (a + b) > m;
        f[2] = ((a % 16) + (b % 16)) >= 16;
        sr   = sa + sb;
        f[5] = (sr > int'(h) - 1) || (sr < -int'(h));
      end else if (op == 2) begin
        f[0] = a < b;
        f[2] = (a % 16) < (b % 16);
        sr   = sa - sb;
        f[5] = (sr > int'(h) - 1) || (sr < -int'(h));
      end
    end
    case (op)
      8: f[6] = 1'b1;  9: f[6] = 1'b0;
      10: f[7] = 1'b1; 11: f[7] = 1'b0;
      12: f[8] = 1'b1; 13: f[8] = 1'b0;
      default: ;
    endcase
    return f;
  endfunction

  task automatic run_op(int op, int unsigned a, int unsigned b, bit w, string req);
    @(negedge clk_i);
    op_i = op[3:0]; op_a_i = a[15:0]; op_b_i = b[15:0]; wide_i = w; upd_i = 1'b1;
    #1;
    check({req, " result"}, {16'h0, result_o}, exp_result(op, a, b, w));
    @(posedge clk_i);
    #1;
    model = exp_flags(op, a, b, w, model);
    check({req, " flags"}, {23'h0, flags_o}, {23'h0, model});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr = 32'h1234_5678;
    repeat (3) @(posedge clk_i);
    #1;
    check("R9 reset flags", {23'h0, flags_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R9: no update strobe, no flag change even for a zero-result add
    @(negedge clk_i);
    op_i = 4'd1; op_a_i = 16'h0080; op_b_i = 16'h0080; wide_i = 0; upd_i = 0;
    @(posedge clk_i); #1;
    check("R9 hold without upd_i", {23'h0, flags_o}, 32'h0);

    // R11: interrupt blocked before enable
    irq_i = 1'b1; #1;
    check("R11 irq blocked", {31'h0, irq_o}, 32'h0);
    check("R11 no trap", {31'h0, trap_o}, 32'h0);

    // R10: control flag commands
    run_op(12, 0, 0, 0, "R10 set dir");
    run_op(13, 0, 0, 0, "R10 clear dir");
    run_op(8, 0, 0, 0, "R10 set trap");
    run_op(10, 0, 0, 0, "R10 set ien");
    run_op(12, 0, 0, 0, "R10 set dir again");
    #1;
    check("R11 irq passed", {31'h0, irq_o}, 32'h1);
    check("R11 trap with upd", {31'h0, trap_o}, 32'h1);
    @(negedge clk_i); upd_i = 1'b0; #1;
    check("R11 trap idle", {31'h0, trap_o}, 32'h0);

    // 8-bit add/sub sweep (R1 R2 R3 R4 R5 R6)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3) begin
        run_op(1, a, b, 0, "R1_R3_R4_R5_R6 add8");
        run_op(2, a, b, 0, "R2_R3_R4_R5_R6 sub8");
      end

    // 8-bit logic sweep, upper operand bits must be ignored (R7)
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 5)
        for (int op = 3; op <= 5; op++)
          run_op(op, a | 16'hA500, b | 16'h5A00, 0, "R7_R5_R6 logic8");

    // 16-bit boundary pairs
    run_op(1, 16'h7FFF, 16'h0001, 1, "R3 add16 overflow");
    run_op(2, 16'h8000, 16'h0001, 1, "R3 sub16 overflow");
    run_op(1, 16'hFFFF, 16'h0001, 1, "R1_R6 add16 wrap zero");
    run_op(2, 16'h0000, 16'h0001, 1, "R2 sub16 borrow");
    run_op(1, 16'h000F, 16'h0001, 1, "R4 add16 half carry");
    run_op(1, 16'h0100, 16'h0000, 1, "R5 parity low byte");

    // R8: passive operations keep flags; move returns masked B
    run_op(6, 16'h1234, 16'hBEEF, 1, "R8 mov16");
    run_op(6, 16'h1234, 16'hBEEF, 0, "R8 mov8");
    run_op(0, 16'h0000, 16'h0000, 1, "R8 nop");
    run_op(7, 16'hFFFF, 16'h0001, 1, "R8 jump");

    // 16-bit pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      int unsigned a16, b16;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a16 = lfsr >> 16;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      b16 = lfsr >> 16;
      if (i % 4 == 0) b16 = a16;
      for (int op = 1; op <= 5; op++)
        run_op(op, a16, b16, 1, "R1_R2_R3_R4_R5_R6_R7 sweep16");
    end

    run_op(11, 0, 0, 1, "R10 clear ien");
    run_op(9, 0, 0, 1, "R10 clear trap");
    #1;
    check("R11 irq blocked again", {31'h0, irq_o}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule